// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block is a 16-bit timer/counter with three compare channels. Each channel drives one waveform pin together with that pin's output enable. A 4-bit waveform mode field selects one of four counting families: free-running, clear-on-compare, single-slope PWM or dual-slope PWM. The same field also selects where the TOP value comes from: full scale, a fixed 8/9/10-bit ceiling, or compare channel A.

Each channel has a 2-bit action code that says what its pin does when the count equals that channel's compare value. In the PWM families the compare values are double-buffered, so a new value cannot cut a period short. The counter and the pins advance only on cycles where the clock enable is high. A prescaler or a software register file sits outside the block and feeds these inputs.

Top module: `timer_wave_unit`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the count direction is up, every pin level is 0 and every buffered compare value is 0.
- R2: Action code 00 drives the channel's output enable low in every mode. A channel whose enable is low keeps its pin level unchanged.
- R3: In single-slope PWM, code 01 enables and toggles only channel A, on its compare match, and only when the mode field is 15. In every other case code 01 drives the enable low.
- R4: In single-slope PWM, code 10 clears the pin on a match and sets it on the tick where the count wraps from TOP to 0. Code 11 sets the pin on a match and clears it on the wrap.
- R5: In single-slope PWM, when a channel's buffered compare value equals TOP and code bit 1 is set, the match is ignored and only the wrap action is applied.
- R6: In dual-slope PWM, code 01 enables and toggles channel A on its match only for mode 9 or 11. Otherwise code 01 drives the enable low.
- R7: In dual-slope PWM, code 10 clears the pin on a match while counting up and sets it on a match while counting down. Code 11 does the opposite. A match is judged by the direction the count takes on that tick, so a match at TOP counts as down-counting and a match at 0 counts as up-counting.
- R8: The mode table, as family/TOP: 0 free/0xFFFF, 1-3 dual/0xFF, 0x1FF, 0x3FF, 4 clear-on-compare/channel A, 5-7 single/0xFF, 0x1FF, 0x3FF, 8 and 10 dual/0xFFFF, 9 and 11 dual/channel A, 12 clear-on-compare/0xFFFF, 13 free/0xFFFF, 14 single/0xFFFF, 15 single/channel A. In free-running, clear-on-compare and single-slope modes, a tick with count at or above TOP sets the count to 0; any other tick adds 1. In dual-slope modes the direction turns down on a tick at or above TOP and turns up on a tick at 0, and the count moves one step in the new direction.
- R9: Compare inputs pass to the buffered values on every clock in the free-running and clear-on-compare modes. In single-slope PWM they load only on a tick at or above TOP. In dual-slope PWM they load only on a tick at 0. Matches and a channel-A TOP always use the buffered values.
- R10: In free-running and clear-on-compare modes, on a match, code 01 toggles, 10 clears and 11 sets the pin, on any channel.
- R11: A cycle with the clock enable low changes neither the count nor any pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable; the timer advances only on cycles where it is high |
| wgm_mode | input | 4 | Waveform mode field (R8) |
| com_mode | input | 2*NCH | Per-channel action code; channel i at bits [2i+1:2i], channel A is i=0 |
| cmp_val | input | NCH*WIDTH | Per-channel compare value; channel i at bits [i*WIDTH +: WIDTH] |
| wave_o | output | NCH | Registered pin levels |
| wave_oe | output | NCH | Pin output enables (combinational from mode and codes) |

## Verification
The pins are the only view of the count. A wrong count or direction therefore shows up as a pin edge that comes early, late or not at all, and only when the next match or wrap arrives. That can be a whole period after the fault, up to 2*TOP ticks in dual-slope mode. A stale or early-loaded compare buffer shows up as a wrong duty cycle in the period after the update point. A wrong enable decode shows up at once on wave_oe. The reference model therefore runs short TOP values and compares every output on every clock, so each such fault surfaces within one short period.

// File: rtl/twu_pkg.sv
// Shared types for the timer waveform unit.
// decode_mode maps the 4-bit mode field to a counting family, a TOP
// source and whether the channel-A toggle code is honoured in PWM.
package twu_pkg;

    typedef enum logic [1:0] {
        FAM_FREE  = 2'd0,
        FAM_CLEAR = 2'd1,
        FAM_SLOPE = 2'd2,
        FAM_DUAL  = 2'd3
    } fam_e;

    typedef enum logic [2:0] {
        TOP_FULL = 3'd0,
        TOP_B8   = 3'd1,
        TOP_B9   = 3'd2,
        TOP_B10  = 3'd3,
        TOP_CHA  = 3'd4
    } topsrc_e;

    typedef struct packed {
        fam_e    fam;
        topsrc_e src;
        logic    tog_a;
    } mode_t;

    // Mode field decode: family, TOP source, channel-A toggle permission.
    function automatic mode_t decode_mode(input logic [3:0] m);
        mode_t r;
        case (m)
            4'd0:    r = '{FAM_FREE,  TOP_FULL, 1'b0};
            4'd1:    r = '{FAM_DUAL,  TOP_B8,   1'b0};
            4'd2:    r = '{FAM_DUAL,  TOP_B9,   1'b0};
            4'd3:    r = '{FAM_DUAL,  TOP_B10,  1'b0};
            4'd4:    r = '{FAM_CLEAR, TOP_CHA,  1'b0};
            4'd5:    r = '{FAM_SLOPE, TOP_B8,   1'b0};
            4'd6:    r = '{FAM_SLOPE, TOP_B9,   1'b0};
            4'd7:    r = '{FAM_SLOPE, TOP_B10,  1'b0};
            4'd8:    r = '{FAM_DUAL,  TOP_FULL, 1'b0};
            4'd9:    r = '{FAM_DUAL,  TOP_CHA,  1'b1};
            4'd10:   r = '{FAM_DUAL,  TOP_FULL, 1'b0};
            4'd11:   r = '{FAM_DUAL,  TOP_CHA,  1'b1};
            4'd12:   r = '{FAM_CLEAR, TOP_FULL, 1'b0};
            4'd13:   r = '{FAM_FREE,  TOP_FULL, 1'b0};
            4'd14:   r = '{FAM_SLOPE, TOP_FULL, 1'b0};
            default: r = '{FAM_SLOPE, TOP_CHA,  1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/twu_counter.sv
// Up/down counter for the waveform unit.
// Single-direction families wrap to 0 on a tick at or above TOP; the
// dual-slope family reverses at TOP and at 0. Assumes top is stable
// within a cycle; advances only when tick is high.
module twu_counter
    import twu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  fam_e             fam,
    input  logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] cnt,
    output logic             at_top,
    output logic             at_bot,
    output logic             step_dn
);

    logic             dir_dn;
    logic [WIDTH-1:0] cnt_nxt;

    // Extremes and the direction this tick will take.
    always_comb begin
        at_top  = (cnt >= top);
        at_bot  = (cnt == '0);
        step_dn = (fam == FAM_DUAL) && (dir_dn ? !at_bot : at_top);
    end

    // Next count value for the selected family.
    always_comb begin
        if (fam == FAM_DUAL)
            cnt_nxt = step_dn ? cnt - 1'b1 : cnt + 1'b1;
        else
            cnt_nxt = at_top ? '0 : cnt + 1'b1;
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_dn <= 1'b0;
        end else if (tick) begin
            cnt    <= cnt_nxt;
            dir_dn <= step_dn;
        end
    end

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam != FAM_DUAL && at_top) |=> (cnt == '0));

    p_dual_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam == FAM_DUAL && !dir_dn && !at_top) |=> (cnt == $past(cnt) + 1'b1));

    p_idle_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/twu_cmp_buf.sv
// Compare value buffers for all channels.
// Transparent (loaded every clock) in the free-running and clear-on-compare
// families; in single-slope PWM loads on a tick at TOP, in dual-slope PWM
// on a tick at 0, so a period never sees a half-updated value.
module twu_cmp_buf
    import twu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  fam_e                 fam,
    input  logic                 at_top,
    input  logic                 at_bot,
    input  logic [NCH*WIDTH-1:0] cmp_in,
    output logic [NCH*WIDTH-1:0] cmp_q
);

    logic load;

    // Update point for the current family.
    always_comb begin
        case (fam)
            FAM_SLOPE: load = tick && at_top;
            FAM_DUAL:  load = tick && at_bot;
            default:   load = 1'b1;
        endcase
    end

    for (genvar i = 0; i < NCH; i++) begin : g_buf
        // One buffered compare value per channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cmp_q[i*WIDTH +: WIDTH] <= '0;
            else if (load)
                cmp_q[i*WIDTH +: WIDTH] <= cmp_in[i*WIDTH +: WIDTH];
        end
    end

    p_slope_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fam == FAM_SLOPE && !(tick && at_top)) |=> $stable(cmp_q));

    p_dual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fam == FAM_DUAL && !(tick && at_bot)) |=> $stable(cmp_q));

endmodule

// File: rtl/twu_channel.sv
// One compare channel: output enable decode and registered pin level.
// Assumes cmp is the buffered compare value and step_dn the direction the
// counter takes on this tick (only meaningful in dual-slope PWM).
module twu_channel
    import twu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  fam_e             fam,
    input  logic [1:0]       code,
    input  logic             tog_ok,
    input  logic [WIDTH-1:0] cmp,
    input  logic [WIDTH-1:0] cnt,
    input  logic             at_top,
    input  logic             step_dn,
    output logic             pin,
    output logic             oe
);

    logic pwm;
    logic hit;
    logic pin_nxt;

    // Pin enable: code 00 off; toggle code in PWM only where permitted.
    always_comb begin
        pwm = (fam == FAM_SLOPE) || (fam == FAM_DUAL);
        oe  = (code != 2'b00) && !(code == 2'b01 && pwm && !tog_ok);
        hit = (cnt == cmp);
    end

    // Next pin level from family, code, match and wrap.
    always_comb begin
        pin_nxt = pin;
        if (tick && oe) begin
            case (fam)
                FAM_SLOPE: begin
                    if (code == 2'b01) begin
                        if (hit) pin_nxt = !pin;
                    end else if (at_top) begin
                        pin_nxt = !code[0];
                    end else if (hit) begin
                        pin_nxt = code[0];
                    end
                end
                FAM_DUAL: begin
                    if (hit) begin
                        if (code == 2'b01) pin_nxt = !pin;
                        else               pin_nxt = step_dn ? !code[0] : code[0];
                    end
                end
                default: begin
                    if (hit) begin
                        if (code == 2'b01) pin_nxt = !pin;
                        else               pin_nxt = code[0];
                    end
                end
            endcase
        end
    end

    // Pin level register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nxt;
    end

    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> $stable(pin));

    p_slope_wrap_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oe && fam == FAM_SLOPE && code[1] && at_top) |=> (pin == !$past(code[0])));

    p_idle_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin));

endmodule

// File: rtl/timer_wave_unit.sv
// Timer compare waveform unit: counter, compare buffers and NCH channels.
// Assumes WIDTH >= 10 so the fixed 8/9/10-bit TOP values fit; channel A
// is channel 0 and supplies TOP in the channel-A modes.
module timer_wave_unit
    import twu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int NCH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [3:0]           wgm_mode,
    input  logic [2*NCH-1:0]     com_mode,
    input  logic [NCH*WIDTH-1:0] cmp_val,
    output logic [NCH-1:0]       wave_o,
    output logic [NCH-1:0]       wave_oe
);

    localparam logic [WIDTH-1:0] TOP8  = WIDTH'((1 << 8) - 1);
    localparam logic [WIDTH-1:0] TOP9  = WIDTH'((1 << 9) - 1);
    localparam logic [WIDTH-1:0] TOP10 = WIDTH'((1 << 10) - 1);

    mode_t                mi;
    logic [WIDTH-1:0]     top;
    logic [WIDTH-1:0]     cnt;
    logic                 at_top;
    logic                 at_bot;
    logic                 step_dn;
    logic [NCH*WIDTH-1:0] cmp_q;

    // Mode decode and TOP selection.
    always_comb begin
        mi = decode_mode(wgm_mode);
        case (mi.src)
            TOP_B8:  top = TOP8;
            TOP_B9:  top = TOP9;
            TOP_B10: top = TOP10;
            TOP_CHA: top = cmp_q[WIDTH-1:0];
            default: top = '1;
        endcase
    end

    twu_counter #(.WIDTH(WIDTH)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .fam     (mi.fam),
        .top     (top),
        .cnt     (cnt),
        .at_top  (at_top),
        .at_bot  (at_bot),
        .step_dn (step_dn)
    );

    twu_cmp_buf #(.WIDTH(WIDTH), .NCH(NCH)) u_cmp_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .fam    (mi.fam),
        .at_top (at_top),
        .at_bot (at_bot),
        .cmp_in (cmp_val),
        .cmp_q  (cmp_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        twu_channel #(.WIDTH(WIDTH)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_en),
            .fam     (mi.fam),
            .code    (com_mode[2*i +: 2]),
            .tog_ok  ((i == 0) && mi.tog_a),
            .cmp     (cmp_q[i*WIDTH +: WIDTH]),
            .cnt     (cnt),
            .at_top  (at_top),
            .step_dn (step_dn),
            .pin     (wave_o[i]),
            .oe      (wave_oe[i])
        );
    end

    p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(wave_o));

    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (wave_o == '0));

endmodule

// File: tb/timer_wave_unit_bench.sv
`timescale 1ns/100ps
module timer_wave_unit_bench;

    localparam int W = 16;
    localparam int N = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic [3:0]     wgm_mode = 4'd0;
    logic [2*N-1:0] com_mode = '0;
    logic [N*W-1:0] cmp_val = '0;
    logic [N-1:0]   wave_o;
    logic [N-1:0]   wave_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    timer_wave_unit u_timer_wave_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wgm_mode (wgm_mode),
        .com_mode (com_mode),
        .cmp_val  (cmp_val),
        .wave_o   (wave_o),
        .wave_oe  (wave_oe)
    );

    // ---------------- reference model ----------------
    // families: 0 free, 1 clear-on-compare, 2 single slope, 3 dual slope
    int m_cnt;
    int m_down;
    int m_cmp [N];
    int m_pin [N];

    function automatic int fam_of(input int m);
        if (m == 0 || m == 13) return 0;
        if (m == 4 || m == 12) return 1;
        if (m == 5 || m == 6 || m == 7 || m == 14 || m == 15) return 2;
        return 3;
    endfunction

    function automatic int top_of(input int m, input int cha);
        if (m == 1 || m == 5) return 255;
        if (m == 2 || m == 6) return 511;
        if (m == 3 || m == 7) return 1023;
        if (m == 4 || m == 9 || m == 11 || m == 15) return cha;
        return 65535;
    endfunction

    function automatic int exp_oe(input int ch, input int code, input int m);
        int f;
        f = fam_of(m);
        if (code == 0) return 0;
        if (code == 1 && f >= 2) begin
            if (ch != 0) return 0;
            if (f == 2) return (m == 15) ? 1 : 0;
            return (m == 9 || m == 11) ? 1 : 0;
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_down = 0;
            for (int i = 0; i < N; i++) begin
                m_cmp[i] = 0;
                m_pin[i] = 0;
            end
        end else begin
            int f, t, code, go_down, load;
            bit at_t, at_b, hit;
            f = fam_of(int'(wgm_mode));
            t = top_of(int'(wgm_mode), m_cmp[0]);
            load = (f < 2) ? 1 : 0;
            if (tick_en) begin
                at_t = (m_cnt >= t);
                at_b = (m_cnt == 0);
                go_down = 0;
                if (f == 3) go_down = m_down ? !at_b : at_t;
                for (int i = 0; i < N; i++) begin
                    code = int'(com_mode[2*i +: 2]);
                    hit = (m_cnt == m_cmp[i]);
                    if (exp_oe(i, code, int'(wgm_mode)) == 1) begin
                        if (code == 1) begin
                            if (hit) m_pin[i] = 1 - m_pin[i];
                        end else if (f == 2) begin
                            if (at_t)     m_pin[i] = (code == 2) ? 1 : 0;
                            else if (hit) m_pin[i] = (code == 2) ? 0 : 1;
                        end else if (f == 3) begin
                            if (hit) m_pin[i] = ((code == 2) == (go_down == 1)) ? 1 : 0;
                        end else begin
                            if (hit) m_pin[i] = (code == 2) ? 0 : 1;
                        end
                    end
                end
                if (f == 3) m_cnt = go_down ? ((m_cnt + 65535) % 65536) : ((m_cnt + 1) % 65536);
                else        m_cnt = at_t ? 0 : ((m_cnt + 1) % 65536);
                m_down = go_down;
                if (f == 2 && at_t) load = 1;
                if (f == 3 && at_b) load = 1;
            end
            if (load == 1)
                for (int i = 0; i < N; i++) m_cmp[i] = int'(cmp_val[i*W +: W]);
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string req);
        for (int i = 0; i < N; i++) begin
            int eo;
            eo = exp_oe(i, int'(com_mode[2*i +: 2]), int'(wgm_mode));
            checks++;
            if (wave_o[i] !== m_pin[i][0] || wave_oe[i] !== eo[0]) begin
                fails++;
                $display("FAIL %s ch%0d mode %0d: pin/oe actual %b/%b expected %0d/%0d",
                         req, i, wgm_mode, wave_o[i], wave_oe[i], m_pin[i], eo);
            end
        end
    endtask

    task automatic run(input int n, input int div, input string req);
        for (int k = 0; k < n; k++) begin
            tick_en = (div <= 1) || (k % div == 0);
            @(posedge clk);
            #1;
            check(req);
        end
    endtask

    task automatic setup(input int m, input int ca, input int cb, input int cc,
                         input int va, input int vb, input int vc);
        rst_n = 1'b0;
        tick_en = 1'b0;
        wgm_mode = 4'(m);
        com_mode = {2'(cc), 2'(cb), 2'(ca)};
        cmp_val  = {16'(vc), 16'(vb), 16'(va)};
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        setup(5, 2, 3, 1, 10, 20, 30);
        checks++;
        if (wave_o !== 3'b000) begin
            fails++;
            $display("FAIL R1 reset pins actual %b expected 000", wave_o);
        end
        check("R1");
        // R10: free-running compare actions on all channels
        setup(0, 1, 2, 3, 7, 40, 90);
        run(300, 1, "R10");
        // R8 R10: clear-on-compare, TOP from channel A, toggles on channel A
        setup(4, 1, 1, 3, 20, 5, 12);
        run(200, 1, "R8_R10");
        // R4 R5: single slope 8-bit, compare 0 and compare TOP
        setup(5, 2, 3, 2, 100, 0, 255);
        run(900, 1, "R4_R5");
        // R5: inverting with compare at TOP
        setup(6, 3, 2, 3, 511, 300, 0);
        run(1300, 1, "R5");
        // R3: mode 15 toggle on A, B disabled; TOP from A
        setup(15, 1, 1, 2, 40, 10, 10);
        run(300, 1, "R3");
        // R3: toggle code in another single-slope mode is off everywhere
        setup(14, 1, 1, 1, 5, 5, 5);
        run(40, 1, "R3");
        // R7 R8: dual slope 8-bit, compare 0, TOP and middle
        setup(1, 2, 3, 2, 0, 255, 77);
        run(1100, 1, "R7_R8");
        // R6 R7: mode 9 toggle on A, B non-inverting, C toggle code off
        setup(9, 1, 2, 1, 30, 12, 12);
        run(300, 1, "R6_R7");
        // R6: mode 11 inverting channels with slow ticks (R11)
        setup(11, 1, 3, 3, 25, 0, 25);
        run(400, 3, "R6_R11");
        // R6: toggle code in a fixed-TOP dual mode is off
        setup(3, 1, 2, 3, 9, 9, 9);
        run(60, 1, "R6");
        // R9: single-slope buffer update mid-period
        setup(5, 2, 2, 3, 50, 60, 70);
        run(300, 1, "R9");
        cmp_val = {16'd20, 16'd200, 16'd180};
        run(600, 1, "R9");
        // R9: dual-slope buffer update mid-period
        setup(9, 2, 2, 3, 40, 10, 30);
        run(100, 1, "R9");
        cmp_val = {16'd5, 16'd35, 16'd60};
        run(300, 1, "R9");
        // R9: clear-on-compare takes new values at once
        setup(4, 3, 1, 2, 50, 10, 30);
        run(70, 1, "R9");
        cmp_val = {16'd8, 16'd3, 16'd30};
        run(120, 1, "R9");
        // R11: gated ticks in single slope
        setup(15, 2, 3, 1, 16, 4, 9);
        run(400, 4, "R11");
        // R2: code 00 on every channel in every mode
        for (int m = 0; m < 16; m++) begin
            setup(m, 0, 0, 0, 2, 3, 4);
            run(20, 1, "R2");
        end
        // R2: disabling a channel mid-run freezes its pin
        setup(5, 2, 3, 2, 30, 30, 60);
        run(300, 1, "R2");
        com_mode = 6'b000000;
        run(300, 1, "R2");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule